// File: doc/BRIEF.md
# 16-bit Card Access Strobe Generator

This block turns one 16-bit card access request into the control strobes of a card socket. A request gives an address and a set of flags: read or write, memory or I/O space, attribute or common memory, DMA, ATA mode, and 8-bit or 16-bit card width. The block then runs the access through three timed phases. First comes setup, where the address and enables settle. Next comes active, where exactly one strobe is low. Last comes hold, where the strobe is high again but the address and enables stay put. When the hold phase ends, the block raises a one-clock done pulse.

Byte lanes follow address parity and width. Enable 1 carries even bytes and enable 2 carries odd bytes. An 8-bit card only ever sees enable 1, and address bit 0 selects the byte. The register-select line has several roles. For memory cycles it picks attribute or common space. For plain I/O cycles it is driven low. For DMA I/O cycles it is held high, which tells the card that DMA is acknowledged. In ATA mode it is always high. The card can stretch the active phase with its asynchronous low-active wait input. That input passes through a two-flop synchroniser and is only examined once the programmed minimum active count has run out.

Top module: `pc16_strobe_gen`

## Requirements
- R1: Out of reset, and whenever no access is in progress, `busy` and `done` are 0 and ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n and reg_n are all 1.
- R2: A request is accepted on a clock edge where `req_valid` is 1 and the block is idle. The three counts are taken at that edge. Setup, active and hold then last exactly cfg_setup, cfg_active and cfg_hold clocks (a count of 0 acts as 1), provided wait stays deasserted. A strobe is low only in the active phase.
- R3: From the first setup clock to the last hold clock, card_addr, ce1_n, ce2_n and reg_n do not change.
- R4: `done` is 1 for exactly one clock: the first idle clock after the hold phase. `busy` is 1 in every setup, active and hold clock. A new request can be accepted in the clock where `done` is 1.
- R5: card_addr equals the accepted address, including bit 0. The enables are asserted as follows. For a 16-bit card at an even address, both ce1_n and ce2_n are 0. For a 16-bit card at an odd address, ce1_n is 1 and ce2_n is 0. For an 8-bit card, ce1_n is 0 and ce2_n is 1 whatever address bit 0 is.
- R6: In the active phase exactly one strobe is low. A memory read drives oe_n, a memory write drives we_n, an I/O read drives iord_n and an I/O write drives iowr_n.
- R7: In a memory cycle outside ATA mode, reg_n is 0 for attribute space and 1 for common space.
- R8: In an I/O cycle outside ATA mode, reg_n is 0 without the DMA flag and 1 with it (DMA acknowledge).
- R9: With the ATA flag set, reg_n stays 1 in every phase, whatever the space, attribute and DMA flags are.
- R10: wait_n passes through two flops and is examined only once the active count has run out. Suppose wait_n is low and is raised just after the n-th active clock. Then the active phase lasts max(cfg_active, n+2) clocks.
- R11: A request presented while busy is ignored. The current access keeps its address, enables and strobe, and no second access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | AW | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_attr | input | 1 | 1 = attribute memory, 0 = common memory |
| req_dma | input | 1 | DMA access flag |
| req_ata | input | 1 | ATA mode flag |
| req_wide | input | 1 | 1 = 16-bit card, 0 = 8-bit card |
| cfg_setup | input | CW | Setup phase length in clocks |
| cfg_active | input | CW | Minimum active phase length in clocks |
| cfg_hold | input | CW | Hold phase length in clocks |
| wait_n | input | 1 | Card wait request, active low, asynchronous |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock end-of-access pulse |
| card_addr | output | AW | Socket address |
| ce1_n | output | 1 | Even byte enable, active low |
| ce2_n | output | 1 | Odd byte enable, active low |
| oe_n | output | 1 | Memory read strobe, active low |
| we_n | output | 1 | Memory write strobe, active low |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O write strobe, active low |
| reg_n | output | 1 | Register select / DMA acknowledge, active low |

## Verification
The assertions assume two things about the inputs. First, request fields only matter at the edge where the block accepts them. Second, wait_n can change at any time, because the logic downstream only sees its synchronised copy. The stimulus follows both rules. Request fields change only at falling edges, and the bench sends junk requests on purpose while an access is running. Before any stretched access, wait_n is pulled low at least four clocks ahead, so the synchroniser already holds the asserted level when the active count runs out. That makes the expected active length max(cfg_active, n+2) exact.

// File: rtl/pc16_pkg.sv
package pc16_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_HOLD   = 2'd3
  } pc16_phase_e;

  typedef struct packed {
    logic write;
    logic io;
    logic attr;
    logic dma;
    logic ata;
    logic wide;
    logic a0;
  } pc16_req_t;

endpackage

// File: rtl/pc16_wait_sync.sv
module pc16_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic wait_n,
  output logic ready
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b1;
    else         sync_q[0] <= wait_n;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b1;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign ready = sync_q[STAGES-1];

endmodule

// File: rtl/pc16_phase_seq.sv
module pc16_phase_seq
  import pc16_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          start,
  input  logic [CW-1:0] cfg_s,
  input  logic [CW-1:0] cfg_a,
  input  logic [CW-1:0] cfg_h,
  input  logic          wait_ok,
  output logic          accept,
  output pc16_phase_e   phase,
  output logic          done
);

  // last count value of a phase; zero is treated as a one-clock phase
  function automatic logic [CW-1:0] last_of(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - CW'(1);
  endfunction

  pc16_phase_e   phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] a_q, h_q;
  logic          done_q, done_d;

  assign accept = start && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          phase_d = PH_SETUP;
          cnt_d   = last_of(cfg_s);
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_ACTIVE;
          cnt_d   = last_of(a_q);
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      PH_ACTIVE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CW'(1);
        end else if (wait_ok) begin
          phase_d = PH_HOLD;
          cnt_d   = last_of(h_q);
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          phase_d = PH_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      a_q     <= '0;
      h_q     <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      if (accept) begin
        a_q <= cfg_a;
        h_q <= cfg_h;
      end
    end
  end

  assign phase = phase_q;
  assign done  = done_q;

  // R2: the active phase is never cut short while its minimum count runs
  assert_active_min_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_q == PH_ACTIVE && cnt_q != '0) |=> (phase_q == PH_ACTIVE));

  // R10: an asserted (synchronised) wait holds the access in the active phase
  assert_wait_holds_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase_q == PH_ACTIVE && cnt_q == '0 && !wait_ok) |=> (phase_q == PH_ACTIVE));

endmodule

// File: rtl/pc16_strobe_decode.sv
module pc16_strobe_decode
  import pc16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  pc16_phase_e phase,
  input  pc16_req_t   req,
  output logic        ce1_n,
  output logic        ce2_n,
  output logic        oe_n,
  output logic        we_n,
  output logic        iord_n,
  output logic        iowr_n,
  output logic        reg_n
);

  logic in_cycle, in_active;

  assign in_cycle  = (phase != PH_IDLE);
  assign in_active = (phase == PH_ACTIVE);

  // byte lanes: 16-bit odd address uses only the odd lane, 8-bit uses lane 1
  assign ce1_n = ~(in_cycle & ~(req.wide & req.a0));
  assign ce2_n = ~(in_cycle & req.wide);

  // register select: ATA forces inactive, DMA I/O signals acknowledge
  assign reg_n = ~in_cycle | req.ata | (req.io ? req.dma : ~req.attr);

  assign oe_n   = ~(in_active & ~req.io & ~req.write);
  assign we_n   = ~(in_active & ~req.io &  req.write);
  assign iord_n = ~(in_active &  req.io & ~req.write);
  assign iowr_n = ~(in_active &  req.io &  req.write);

  // R6: never two strobes at once
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({~oe_n, ~we_n, ~iord_n, ~iowr_n}));

  // R5: a strobe always has at least one byte lane enabled
  assert_strobe_has_lane_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!oe_n || !we_n || !iord_n || !iowr_n) |-> (!ce1_n || !ce2_n));

  // R1: an idle socket is fully quiet
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    (phase == PH_IDLE) |->
      (ce1_n && ce2_n && oe_n && we_n && iord_n && iowr_n && reg_n));

endmodule

// File: rtl/pc16_strobe_gen.sv
module pc16_strobe_gen
  import pc16_pkg::*;
#(
  parameter int AW          = 12,
  parameter int CW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic          req_io,
  input  logic          req_attr,
  input  logic          req_dma,
  input  logic          req_ata,
  input  logic          req_wide,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_active,
  input  logic [CW-1:0] cfg_hold,
  input  logic          wait_n,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] card_addr,
  output logic          ce1_n,
  output logic          ce2_n,
  output logic          oe_n,
  output logic          we_n,
  output logic          iord_n,
  output logic          iowr_n,
  output logic          reg_n
);

  localparam int RS_STAGES = 2;

  logic [RS_STAGES-1:0] rst_sync_q;
  logic                 rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[RS_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_sync_q[RS_STAGES-1];

  logic          accept;
  logic          wait_ok;
  pc16_phase_e   phase;
  pc16_req_t     req_q, req_d;
  logic [AW-1:0] addr_q;

  always_comb begin
    req_d.write = req_write;
    req_d.io    = req_io;
    req_d.attr  = req_attr;
    req_d.dma   = req_dma;
    req_d.ata   = req_ata;
    req_d.wide  = req_wide;
    req_d.a0    = req_addr[0];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      req_q  <= '0;
      addr_q <= '0;
    end else if (accept) begin
      req_q  <= req_d;
      addr_q <= req_addr;
    end
  end

  pc16_wait_sync #(.STAGES(SYNC_STAGES)) u_wsync (
    .clk    (clk),
    .rst_ni (rst_i),
    .wait_n (wait_n),
    .ready  (wait_ok)
  );

  pc16_phase_seq #(.CW(CW)) u_seq (
    .clk     (clk),
    .rst_ni  (rst_i),
    .start   (req_valid),
    .cfg_s   (cfg_setup),
    .cfg_a   (cfg_active),
    .cfg_h   (cfg_hold),
    .wait_ok (wait_ok),
    .accept  (accept),
    .phase   (phase),
    .done    (done)
  );

  pc16_strobe_decode u_dec (
    .clk    (clk),
    .rst_ni (rst_i),
    .phase  (phase),
    .req    (req_q),
    .ce1_n  (ce1_n),
    .ce2_n  (ce2_n),
    .oe_n   (oe_n),
    .we_n   (we_n),
    .iord_n (iord_n),
    .iowr_n (iowr_n),
    .reg_n  (reg_n)
  );

  assign busy      = (phase != PH_IDLE);
  assign card_addr = addr_q;

  // R4: the end-of-access pulse lasts one clock
  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !done);

  // R3, R11: address, lanes and select hold still for the whole access
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && $past(busy)) |->
      ($stable(card_addr) && $stable(ce1_n) && $stable(ce2_n) && $stable(reg_n)));

endmodule

// File: tb/pc16_strobe_gen_test.sv
module pc16_strobe_gen_test;

  localparam int AW = 12;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          req_write, req_io, req_attr, req_dma, req_ata, req_wide;
  logic [CW-1:0] cfg_setup, cfg_active, cfg_hold;
  logic          wait_n;
  logic          busy, done;
  logic [AW-1:0] card_addr;
  logic          ce1_n, ce2_n, oe_n, we_n, iord_n, iowr_n, reg_n;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  pc16_strobe_gen #(.AW(AW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_io(req_io), .req_attr(req_attr),
    .req_dma(req_dma), .req_ata(req_ata), .req_wide(req_wide),
    .cfg_setup(cfg_setup), .cfg_active(cfg_active), .cfg_hold(cfg_hold),
    .wait_n(wait_n), .busy(busy), .done(done), .card_addr(card_addr),
    .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n), .we_n(we_n),
    .iord_n(iord_n), .iowr_n(iowr_n), .reg_n(reg_n)
  );

  task automatic chk(input bit ok, input string tag, input int actv, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actv, expv);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [3:0] strobes();
    return {oe_n, we_n, iord_n, iowr_n};
  endfunction

  // flags: [0]write [1]io [2]attr [3]dma [4]ata [5]wide [6]addr bit0
  task automatic run_txn(input logic [6:0] fl, input int s, input int a, input int h,
                         input int rel, input bit poke);
    logic [AW-1:0] addr;
    logic          e_ce1, e_ce2, e_reg;
    logic [3:0]    e_stb;
    int            n_set, n_act, n_hold, exp_act;
    bit            first;
    addr  = {11'(fl * 13 + 5), fl[6]};
    e_ce1 = fl[5] ? fl[6] : 1'b0;
    e_ce2 = fl[5] ? 1'b0 : 1'b1;
    e_reg = fl[4] ? 1'b1 : (fl[1] ? fl[3] : ~fl[2]);
    e_stb = 4'b1111;
    e_stb[3 - {fl[1], fl[0]}] = 1'b0;   // order oe, we, iord, iowr
    req_addr = addr; req_write = fl[0]; req_io = fl[1]; req_attr = fl[2];
    req_dma = fl[3]; req_ata = fl[4]; req_wide = fl[5];
    cfg_setup = CW'(s); cfg_active = CW'(a); cfg_hold = CW'(h);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n_set = 0; n_act = 0; n_hold = 0; first = 1'b1;
    while (busy) begin
      chk(card_addr == addr, "R5 address", int'(card_addr), int'(addr));
      chk(ce1_n == e_ce1 && ce2_n == e_ce2, "R5 lanes", int'({ce1_n, ce2_n}), int'({e_ce1, e_ce2}));
      chk(reg_n == e_reg, fl[4] ? "R9 ata select" : (fl[1] ? "R8 io select" : "R7 mem select"),
          int'(reg_n), int'(e_reg));
      chk(done == 1'b0, "R4 done while busy", int'(done), 0);
      if (strobes() != 4'b1111) begin
        n_act++;
        chk(strobes() == e_stb, "R6 strobe", int'(strobes()), int'(e_stb));
        chk(n_hold == 0, "R2 strobe after hold", n_hold, 0);
      end else if (n_act == 0) n_set++;
      else n_hold++;
      if (poke && first) begin
        req_valid = 1'b1; req_addr = ~addr; req_write = ~fl[0]; req_io = ~fl[1];
      end else req_valid = 1'b0;
      first = 1'b0;
      if (rel > 0 && n_act == rel) wait_n = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    exp_act = (rel > 0) ? ((eff(a) > rel + 2) ? eff(a) : rel + 2) : eff(a);
    chk(n_set == eff(s), "R2 setup length", n_set, eff(s));
    chk(n_act == exp_act, rel > 0 ? "R10 stretched active" : "R2 active length", n_act, exp_act);
    chk(n_hold == eff(h), "R2 hold length", n_hold, eff(h));
    chk(done == 1'b1, "R4 done pulse", int'(done), 1);
    chk({ce1_n, ce2_n, strobes(), reg_n} == 7'h7f, "R1 idle quiet",
        int'({ce1_n, ce2_n, strobes(), reg_n}), 127);
    if (poke) begin
      @(negedge clk);
      chk(busy == 1'b0 && done == 1'b0, "R11 busy request ignored", int'({busy, done}), 0);
    end
    wait_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0;
    req_write = 0; req_io = 0; req_attr = 0; req_dma = 0; req_ata = 0; req_wide = 0;
    cfg_setup = 4'd2; cfg_active = 4'd4; cfg_hold = 4'd1; wait_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 reset busy/done", int'({busy, done}), 0);
    chk({ce1_n, ce2_n, strobes(), reg_n} == 7'h7f, "R1 reset outputs",
        int'({ce1_n, ce2_n, strobes(), reg_n}), 127);

    // default timing first, then every flag combination with swept counts
    run_txn(7'b0100000, 2, 4, 1, 0, 1'b0);
    for (int f = 0; f < 128; f++) begin
      run_txn(7'(f), f % 4, (f / 4) % 4, (f / 16) % 3, 0, (f % 16) == 5);
    end

    // wait stretching: released early (no effect) and late (extends)
    for (int r = 1; r <= 5; r++) begin
      wait_n = 1'b0;
      repeat (4) @(negedge clk);
      run_txn(7'(r * 9), 2, 3, 1, r, 1'b0);
    end
    wait_n = 1'b0;
    repeat (4) @(negedge clk);
    run_txn(7'b0100010, 1, 0, 0, 2, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule